// File: doc/BRIEF.md
# Timer Channel Command and Interrupt Register Front End

This block is the software-facing register layer of one timer channel with a 16-bit counter. It sits on a simple memory-mapped bus with address, write enable, read enable and 32-bit data. It turns writes into one-cycle command pulses for the counter core: clock on, clock off and software trigger. It also holds the channel mode word that the core decodes.

The counter core reports events to this block as single-cycle strobes. The block latches them into eight sticky status flags. A 1 written to the enable offset sets a bit in the interrupt mask, and a 1 written to the disable offset clears it. A single level-sensitive interrupt line is high while any flag is set whose mask bit is also set.

Reading the status word returns the flags together with three live bits (clock running, pin A level, pin B level) and then clears the flags. The block tracks whether captured values A and B have been read, and sets the load-overrun flag when one of them is overwritten before software has read it.

Top module: `tmr_chan_regs`

## Requirements
- R1: Read map (byte offsets): mode word at 0x04 is read/write; counter value 0x10, A 0x14, B 0x18 and C 0x1C read the core inputs zero-extended, and writes there are ignored; the mask reads at 0x2C; the command (0x00), mask-set (0x24) and mask-clear (0x28) offsets read as 0.
- R2: A write to 0x00 produces, in the following cycle only, a one-cycle pulse on each command output whose data bit is 1: bit 0 clock on, bit 1 clock off, bit 2 software trigger. A data bit of 0 produces nothing.
- R3: If bits 0 and 1 are both 1 in one command write, only the clock-off pulse is issued.
- R4: Status bit 16 shows the clock-running input live, and bits 17 and 18 show the pin A and pin B levels live.
- R5: Status bits 0..7 are sticky flags: 0 overflow, 1 load overrun, 2 compare A, 3 compare B, 4 compare C, 5 A loaded, 6 B loaded, 7 external trigger. A strobe sets its flag, and the flag stays set until the status word is read. The read returns the flag and clears it.
- R6: A strobe that arrives in the same cycle as a status read is not lost: the read returns the old flags, and the new flag is set afterwards.
- R7: Mode bit 15 selects waveform operation. When it is 1, the A-loaded and B-loaded strobes are ignored. When it is 0, the compare-A and compare-B strobes are ignored.
- R8: In capture mode (mode bit 15 = 0), load overrun is set when A, or B, is loaded a second time without a read of that register at 0x14 or 0x18 in between. A read in the same cycle as a load counts as reading the previous value.
- R9: A write to 0x24 sets the mask bits where data bits 7..0 are 1. A write to 0x28 clears the mask bits where data bits are 1. Zero bits leave the mask unchanged.
- R10: The interrupt output is high exactly while some status flag 0..7 is set together with its mask bit.
- R11: After reset, the mode word, the mask, the flags, the interrupt and the command outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle rd_en is high |
| cnt_val | input | CNT_W | Live counter value from the core |
| cap_a | input | CNT_W | Register A value from the core |
| cap_b | input | CNT_W | Register B value from the core |
| cmp_c | input | CNT_W | Register C value from the core |
| ev_ovf | input | 1 | Counter overflow strobe |
| ev_cmp_a | input | 1 | Compare A strobe |
| ev_cmp_b | input | 1 | Compare B strobe |
| ev_cmp_c | input | 1 | Compare C strobe |
| ev_ld_a | input | 1 | A loaded strobe |
| ev_ld_b | input | 1 | B loaded strobe |
| ev_ext_trig | input | 1 | External trigger strobe |
| clk_running | input | 1 | Counter clock enabled state |
| pin_a | input | 1 | Pin A level |
| pin_b | input | 1 | Pin B level |
| cmd_clk_on | output | 1 | Clock on command pulse |
| cmd_clk_off | output | 1 | Clock off command pulse |
| cmd_sw_trig | output | 1 | Software trigger command pulse |
| mode | output | 32 | Mode word for the counter core |
| irq | output | 1 | Level interrupt |

## Verification
A flag that is lost or stuck shows up at the next status read. It also shows on the interrupt line in the cycle after the strobe, once the matching mask bit is set. A stale pending-load bit only becomes visible on the second load, when the overrun flag is set when it should not be or stays clear when it should be set. Each flag is therefore driven with the capture values read between loads and without such reads. A wrong mask bit appears immediately in the mask read-back and in the interrupt level. A fault in command decode appears one cycle after the write, on the pulse outputs.

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [CNT_W-1:0]  cap_a,
  input  logic [CNT_W-1:0]  cap_b,
  input  logic [CNT_W-1:0]  cmp_c,
  input  logic              ev_ovf,
  input  logic              ev_cmp_a,
  input  logic              ev_cmp_b,
  input  logic              ev_cmp_c,
  input  logic              ev_ld_a,
  input  logic              ev_ld_b,
  input  logic              ev_ext_trig,
  input  logic              clk_running,
  input  logic              pin_a,
  input  logic              pin_b,
  output logic              cmd_clk_on,
  output logic              cmd_clk_off,
  output logic              cmd_sw_trig,
  output logic [31:0]       mode,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_CMD  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_MODE = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_CNT  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_A    = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFF_B    = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFF_C    = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] OFF_MSET = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] OFF_MCLR = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(8'h2C);
  localparam int WAVE_BIT = 15;

  logic [7:0] flags, mask, new_ev;
  logic       pend_a, pend_b;

  wire wr_cmd  = wr_en && addr == OFF_CMD;
  wire wr_mode = wr_en && addr == OFF_MODE;
  wire wr_mset = wr_en && addr == OFF_MSET;
  wire wr_mclr = wr_en && addr == OFF_MCLR;
  wire rd_stat = rd_en && addr == OFF_STAT;
  wire rd_a    = rd_en && addr == OFF_A;
  wire rd_b    = rd_en && addr == OFF_B;

  wire wave  = mode[WAVE_BIT];
  wire ld_a  = ev_ld_a & ~wave;
  wire ld_b  = ev_ld_b & ~wave;
  wire ovr_a = ld_a & pend_a & ~rd_a;
  wire ovr_b = ld_b & pend_b & ~rd_b;

  assign new_ev = {ev_ext_trig, ld_b, ld_a, ev_cmp_c,
                   ev_cmp_b & wave, ev_cmp_a & wave, ovr_a | ovr_b, ev_ovf};
  assign irq = |(flags & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= '0;
      flags       <= '0;
      mask        <= '0;
      pend_a      <= 1'b0;
      pend_b      <= 1'b0;
      cmd_clk_on  <= 1'b0;
      cmd_clk_off <= 1'b0;
      cmd_sw_trig <= 1'b0;
    end else begin
      if (wr_mode) mode <= wdata;
      flags <= (rd_stat ? 8'h00 : flags) | new_ev;
      mask  <= (mask | (wr_mset ? wdata[7:0] : 8'h00)) & ~(wr_mclr ? wdata[7:0] : 8'h00);
      pend_a <= rd_a ? ld_a : (pend_a | ld_a);
      pend_b <= rd_b ? ld_b : (pend_b | ld_b);
      cmd_clk_off <= wr_cmd & wdata[1];
      cmd_clk_on  <= wr_cmd & wdata[0] & ~wdata[1];
      cmd_sw_trig <= wr_cmd & wdata[2];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFF_MODE: rdata = mode;
        OFF_CNT:  rdata = 32'(cnt_val);
        OFF_A:    rdata = 32'(cap_a);
        OFF_B:    rdata = 32'(cap_b);
        OFF_C:    rdata = 32'(cmp_c);
        OFF_STAT: rdata = {13'h0, pin_b, pin_a, clk_running, 8'h00, flags};
        OFF_MASK: rdata = {24'h0, mask};
        default:  rdata = '0;
      endcase
    end
  end

  AST_CMD_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata[1]) |=> (cmd_clk_off && !cmd_clk_on)); // R3
  AST_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> !(cmd_clk_on || cmd_clk_off || cmd_sw_trig)); // R2
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> ((flags & $past(flags)) == $past(flags))); // R5
  AST_OVF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && ev_ovf) |=> flags[0]); // R6
  AST_NO_OVERRUN_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wave && !flags[1]) |=> !flags[1]); // R8
  AST_NO_CMPA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wave && !flags[2]) |=> !flags[2]); // R7
  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> ((mask & $past(wdata[7:0])) == 8'h00)); // R9
endmodule

// File: tb/tb_tmr_chan_regs.sv
module tb_tmr_chan_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, rdata, mode;
  logic [15:0] cnt_val = 16'h1234, cap_a = 16'hA0A0, cap_b = 16'hB0B0, cmp_c = 16'hC0C0;
  logic ev_ovf = 0, ev_cmp_a = 0, ev_cmp_b = 0, ev_cmp_c = 0, ev_ld_a = 0, ev_ld_b = 0, ev_ext_trig = 0;
  logic clk_running = 0, pin_a = 0, pin_b = 0;
  logic cmd_clk_on, cmd_clk_off, cmd_sw_trig, irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;
  logic [7:0] exp_mask;

  always #10 clk = ~clk;

  tmr_chan_regs dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cnt_val(cnt_val), .cap_a(cap_a), .cap_b(cap_b), .cmp_c(cmp_c),
    .ev_ovf(ev_ovf), .ev_cmp_a(ev_cmp_a), .ev_cmp_b(ev_cmp_b), .ev_cmp_c(ev_cmp_c),
    .ev_ld_a(ev_ld_a), .ev_ld_b(ev_ld_b), .ev_ext_trig(ev_ext_trig), .clk_running(clk_running),
    .pin_a(pin_a), .pin_b(pin_b), .cmd_clk_on(cmd_clk_on), .cmd_clk_off(cmd_clk_off),
    .cmd_sw_trig(cmd_sw_trig), .mode(mode), .irq(irq));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #2 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_ev(int i, logic v);
    case (i)
      0: ev_ovf = v; 2: ev_cmp_a = v; 3: ev_cmp_b = v; 4: ev_cmp_c = v;
      5: ev_ld_a = v; 6: ev_ld_b = v; 7: ev_ext_trig = v; default: ;
    endcase
  endtask

  task automatic pulse(int i);
    @(negedge clk); set_ev(i, 1'b1);
    @(negedge clk); set_ev(i, 1'b0);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 irq", {31'h0, irq}, 32'h0);
    chk("R11 mode", mode, 32'h0);
    chk("R11 cmd", {29'h0, cmd_clk_on, cmd_clk_off, cmd_sw_trig}, 32'h0);
    rd(8'h20, rv); chk("R11 status", rv, 32'h0);
    rd(8'h2C, rv); chk("R11 mask", rv, 32'h0);

    // R1 read map
    wr(8'h04, 32'h5A5A_0003); rd(8'h04, rv); chk("R1 mode rw", rv, 32'h5A5A_0003);
    chk("R1 mode port", mode, 32'h5A5A_0003);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, rv); chk("R1 cnt", rv, 32'h1234);
    rd(8'h14, rv); chk("R1 A", rv, 32'hA0A0);
    rd(8'h18, rv); chk("R1 B", rv, 32'hB0B0);
    rd(8'h1C, rv); chk("R1 C", rv, 32'hC0C0);
    rd(8'h00, rv); chk("R1 cmd reads 0", rv, 32'h0);
    rd(8'h24, rv); chk("R1 mset reads 0", rv, 32'h0);
    rd(8'h28, rv); chk("R1 mclr reads 0", rv, 32'h0);
    wr(8'h04, 32'h0);

    // R2, R3 command sweep
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); addr = 8'h00; wdata = 32'(c); wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
      chk($sformatf("R2 R3 cmd %0d", c), {29'h0, cmd_clk_on, cmd_clk_off, cmd_sw_trig},
          {29'h0, c[0] & ~c[1], c[1], c[2]});
      @(negedge clk);
      chk($sformatf("R2 one-cycle %0d", c), {29'h0, cmd_clk_on, cmd_clk_off, cmd_sw_trig}, 32'h0);
    end

    // R4 live bits
    for (int v = 0; v < 8; v++) begin
      {pin_b, pin_a, clk_running} = 3'(v);
      rd(8'h20, rv); chk($sformatf("R4 live %0d", v), rv, 32'(v) << 16);
    end
    {pin_b, pin_a, clk_running} = 3'b000;

    // R5, R10 flag and mask sweep
    exp_mask = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (i == 1) continue;
      wr(8'h04, (i == 2 || i == 3) ? 32'h8000 : 32'h0);
      for (int m = 0; m < 2; m++) begin
        if (m == 1) wr(8'h24, 32'(1 << i)); else wr(8'h28, 32'hFF);
        rd(8'h14, rv); rd(8'h18, rv); rd(8'h20, rv);
        pulse(i);
        chk($sformatf("R10 irq bit%0d mask%0d", i, m), {31'h0, irq}, 32'(m));
        @(negedge clk);
        chk($sformatf("R5 held bit%0d", i), {31'h0, irq}, 32'(m));
        rd(8'h20, rv); chk($sformatf("R5 flag bit%0d", i), rv, 32'(1 << i));
        chk($sformatf("R10 irq clear bit%0d", i), {31'h0, irq}, 32'h0);
        rd(8'h20, rv); chk($sformatf("R5 cleared bit%0d", i), rv, 32'h0);
      end
    end
    wr(8'h28, 32'hFF);

    // R7 mode gating
    wr(8'h04, 32'h0); pulse(2); pulse(3);
    rd(8'h20, rv); chk("R7 cmp ignored in capture", rv, 32'h0);
    wr(8'h04, 32'h8000); pulse(5); pulse(6); pulse(5);
    rd(8'h20, rv); chk("R7 loads ignored in waveform", rv, 32'h0);
    wr(8'h04, 32'h0);

    // R6 event during status read
    pulse(4);
    @(negedge clk); addr = 8'h20; rd_en = 1'b1; ev_ovf = 1'b1;
    #2 rv = rdata;
    @(negedge clk); rd_en = 1'b0; ev_ovf = 1'b0;
    chk("R6 read returns old", rv, 32'h10);
    rd(8'h20, rv); chk("R6 event kept", rv, 32'h1);

    // R8 overrun
    rd(8'h14, rv); rd(8'h18, rv);
    pulse(5); pulse(5);
    rd(8'h20, rv); chk("R8 A twice", rv, 32'h22);
    rd(8'h14, rv); pulse(5); rd(8'h14, rv); pulse(5);
    rd(8'h20, rv); chk("R8 A read between", rv, 32'h20);
    rd(8'h14, rv);
    pulse(6); pulse(6);
    rd(8'h20, rv); chk("R8 B twice", rv, 32'h42);
    rd(8'h18, rv);
    pulse(6);
    @(negedge clk); addr = 8'h18; rd_en = 1'b1; ev_ld_b = 1'b1;
    @(negedge clk); rd_en = 1'b0; ev_ld_b = 1'b0;
    rd(8'h20, rv); chk("R8 read with load", rv, 32'h40);
    pulse(6);
    rd(8'h20, rv); chk("R8 after read with load", rv, 32'h42);
    rd(8'h18, rv);

    // R9 mask set/clear sweep
    exp_mask = 8'h00;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] p, q;
      p = 8'(k * 37 + 5); q = 8'(k * 91 + 3);
      wr(8'h24, {24'hFFFFFF, p}); exp_mask = exp_mask | p;
      rd(8'h2C, rv); chk($sformatf("R9 set %0d", k), rv, {24'h0, exp_mask});
      wr(8'h28, {24'hFFFFFF, q}); exp_mask = exp_mask & ~q;
      rd(8'h2C, rv); chk($sformatf("R9 clr %0d", k), rv, {24'h0, exp_mask});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule